// File: doc/BRIEF.md
# Interrupt Coalescing Status Unit

This unit gathers the event pulses of a descriptor-ring Ethernet MAC into one interrupt line. Every event source sets a sticky bit in a 32-bit raw event register. Software clears a bit by writing a one to it. An enable register masks the raw bits into a status view. The interrupt output is a registered OR of that status view.

Two event sources are not taken straight from the event inputs, because they come from coalescing logic: the receive-done queue and the transmit-reclaim queue. For each of these queues the unit counts completed descriptors and raises a "queue in" bit once the count reaches a programmed threshold. If descriptors are pending and the threshold is not reached within a programmed number of cycles, the unit raises a separate timeout bit instead. Both count thresholds are held in one register. Each queue has its own timeout register.

Top module: `irq_coal_top`

## Requirements
- R1: When `evt_i` bit b is high at a clock edge, raw bit b is set at that edge and stays set until it is cleared. This holds for every bit except the coalesced positions 17, 19, 28 and 29, where `evt_i` is ignored.
- R2: A write to select 0 (raw) with a one in bit b clears raw bit b. Raw bits written with zero keep their value.
- R3: When a clearing write and a new event hit the same raw bit in the same cycle, the bit ends set.
- R4: Select 2 reads as raw AND enable. Select 1 is the enable register and is written and read there. With the enable register at zero the status reads zero, and the raw bits keep their value.
- R5: `irq_o` equals the OR of all status bits as they stood before the previous clock edge, so it lags a status change by exactly one cycle.
- R6: Select 3 holds the receive-done count threshold in bits 15:0 and the transmit-reclaim count threshold in bits 31:16. A threshold of zero acts as one. The receive-done queue sets raw bit 17 on the `rx_done_i` pulse that brings its pending count up to the threshold. The transmit-reclaim queue does the same for raw bit 19 with `tx_done_i`.
- R7: Select 4 holds the receive-done timeout T and select 5 holds the transmit-reclaim timeout T. If a queue's count threshold is not reached, its timeout bit sets exactly T cycles after the edge that captured the queue's first pending pulse: bit 28 for receive-done, bit 29 for transmit-reclaim. A value of T equal to zero disables the timeout.
- R8: When a queue's threshold event or timeout event fires, the queue's pending count and its timeout counter return to zero.
- R9: After reset the raw register, the enable register and `irq_o` read 0, select 3 reads 0x00010001, select 4 reads 0x10000 and select 5 reads 0x50000.
- R10: Writes to select 2 change no register. Each register reads back through `reg_rsel` at the select it is written at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per raw bit |
| rx_done_i | input | 1 | One receive descriptor completed |
| tx_done_i | input | 1 | One transmit descriptor reclaimed |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 3 | Register select for the write |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 3 | Register select for the read |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Interrupt line |

## Verification
The pending count and the timeout counter cannot be seen from outside the block. A wrong pending count therefore shows up only as bit 17 or 19 appearing one pulse early or late. A counter that is not cleared after an event shows up as a threshold reached too early on the next burst. A wrong timeout counter shows up as bit 28 or 29 rising a cycle off from T, or rising when T is zero. The bench counts cycles to the exact edge on each of these cases. A flaw in the raw-register update shows up in the very next read, so it is checked cycle by cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned RX_IN_BIT  = 17;
  localparam int unsigned TX_IN_BIT  = 19;
  localparam int unsigned RX_TMO_BIT = 28;
  localparam int unsigned TX_TMO_BIT = 29;
  localparam logic [31:0] COAL_MASK  = (32'd1 << RX_IN_BIT) | (32'd1 << TX_IN_BIT) |
                                       (32'd1 << RX_TMO_BIT) | (32'd1 << TX_TMO_BIT);
  localparam int unsigned NUM_QUEUES = 2;

  typedef enum logic [2:0] {
    SEL_RAW   = 3'd0,
    SEL_ENA   = 3'd1,
    SEL_STAT  = 3'd2,
    SEL_QTH   = 3'd3,
    SEL_RXTMO = 3'd4,
    SEL_TXTMO = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/irq_coal_queue.sv
module irq_coal_queue #(
  parameter int unsigned CW = 16,
  parameter int unsigned TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [CW-1:0] cnt_th_i,
  input  logic [TW-1:0] tmo_th_i,
  output logic          hit_o,
  output logic          tmo_o
);
  logic [CW-1:0] pend_q, pend_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [CW-1:0] th_eff;
  logic [CW:0]   pend_inc;
  logic [TW:0]   tmr_inc;
  logic          pend_nz;

  always_comb begin
    th_eff   = (cnt_th_i == '0) ? CW'(1) : cnt_th_i;
    pend_inc = {1'b0, pend_q} + (CW+1)'(1);
    tmr_inc  = {1'b0, tmr_q} + (TW+1)'(1);
    pend_nz  = (pend_q != '0);
    hit_o    = done_i && (pend_inc >= {1'b0, th_eff});
    tmo_o    = !hit_o && pend_nz && (tmo_th_i != '0) && (tmr_inc >= {1'b0, tmo_th_i});
    pend_d   = pend_q;
    tmr_d    = tmr_q;
    if (hit_o || tmo_o) begin
      pend_d = '0;
      tmr_d  = '0;
    end else begin
      if (done_i) pend_d = pend_inc[CW-1:0];
      if (pend_nz && (tmr_q != '1)) tmr_d = tmr_inc[TW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      tmr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      tmr_q  <= tmr_d;
    end
  end

  AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (pend_q == '0 && tmr_q == '0)); // R8
  AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |=> (pend_q == '0 && tmr_q == '0)); // R8
  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (tmr_q == '0)); // R7
endmodule

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] raw_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q, raw_d;
  logic         irq_q, irq_d;

  always_comb begin
    raw_d = (raw_q & ~clr_i) | set_i;
    irq_d = |(raw_q & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      irq_q <= irq_d;
    end
  end

  assign raw_o = raw_q;
  assign irq_o = irq_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((raw_q & $past(clr_i & ~set_i)) == '0)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i))); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_q); // R5
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned TW      = 32,
  parameter logic [W-1:0]  QTH_RST = 32'h0001_0001,
  parameter logic [TW-1:0] RX_TMO_RST = 32'h0001_0000,
  parameter logic [TW-1:0] TX_TMO_RST = 32'h0005_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  qth_o,
  output logic [TW-1:0] rx_tmo_o,
  output logic [TW-1:0] tx_tmo_o
);
  logic [W-1:0]  en_q, qth_q;
  logic [TW-1:0] rxt_q, txt_q;
  logic          en_we, qth_we, rxt_we, txt_we;

  always_comb begin
    en_we  = we_i && (sel_i == SEL_ENA);
    qth_we = we_i && (sel_i == SEL_QTH);
    rxt_we = we_i && (sel_i == SEL_RXTMO);
    txt_we = we_i && (sel_i == SEL_TXTMO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      qth_q <= QTH_RST;
      rxt_q <= RX_TMO_RST;
      txt_q <= TX_TMO_RST;
    end else begin
      if (en_we)  en_q  <= wdata_i;
      if (qth_we) qth_q <= wdata_i;
      if (rxt_we) rxt_q <= wdata_i[TW-1:0];
      if (txt_we) txt_q <= wdata_i[TW-1:0];
    end
  end

  assign en_o     = en_q;
  assign qth_o    = qth_q;
  assign rx_tmo_o = rxt_q;
  assign tx_tmo_o = txt_q;

  AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i == SEL_STAT) |=> ($stable(en_q) && $stable(qth_q) &&
                                     $stable(rxt_q) && $stable(txt_q))); // R10
endmodule

// File: rtl/irq_coal_top.sv
module irq_coal_top
  import irq_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned TW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         rx_done_i,
  input  logic         tx_done_i,
  input  logic         reg_we,
  input  logic [2:0]   reg_wsel,
  input  logic [W-1:0] reg_wdata,
  input  logic [2:0]   reg_rsel,
  output logic [W-1:0] reg_rdata,
  output logic         irq_o
);
  localparam int unsigned CW = W / 2;

  logic [W-1:0]  en, qth, raw, set_vec, clr_vec;
  logic [TW-1:0] rx_tmo, tx_tmo;
  logic [NUM_QUEUES-1:0] done_v, hit_v, tmo_v;

  irq_cfg_regs #(.W(W), .TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .sel_i(reg_wsel), .wdata_i(reg_wdata),
    .en_o(en), .qth_o(qth), .rx_tmo_o(rx_tmo), .tx_tmo_o(tx_tmo)
  );

  assign done_v = {tx_done_i, rx_done_i};

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
    irq_coal_queue #(.CW(CW), .TW(TW)) u_q (
      .clk(clk), .rst_n(rst_n), .done_i(done_v[q]),
      .cnt_th_i(qth[q*CW +: CW]),
      .tmo_th_i((q == 0) ? rx_tmo : tx_tmo),
      .hit_o(hit_v[q]), .tmo_o(tmo_v[q])
    );
  end

  always_comb begin
    set_vec             = evt_i & ~COAL_MASK;
    set_vec[RX_IN_BIT]  = hit_v[0];
    set_vec[TX_IN_BIT]  = hit_v[1];
    set_vec[RX_TMO_BIT] = tmo_v[0];
    set_vec[TX_TMO_BIT] = tmo_v[1];
    clr_vec = (reg_we && reg_wsel == SEL_RAW) ? reg_wdata : '0;
  end

  irq_raw_bank #(.W(W)) u_raw (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .en_i(en),
    .raw_o(raw), .irq_o(irq_o)
  );

  always_comb begin
    case (reg_rsel)
      SEL_RAW:   reg_rdata = raw;
      SEL_ENA:   reg_rdata = en;
      SEL_STAT:  reg_rdata = raw & en;
      SEL_QTH:   reg_rdata = qth;
      SEL_RXTMO: reg_rdata = W'(rx_tmo);
      SEL_TXTMO: reg_rdata = W'(tx_tmo);
      default:   reg_rdata = '0;
    endcase
  end

  AST_COAL_BITS_FROM_QUEUES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_v == '0 && tmo_v == '0) |=> ((raw & COAL_MASK & ~$past(raw)) == '0)); // R6
endmodule

// File: tb/sim_irq_coal_top.sv
module sim_irq_coal_top;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [2:0]  wsel;
    logic [31:0] wdata;
    logic [31:0] evt;
    logic        rx;
    logic        tx;
    logic [2:0]  rsel;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd0, 32'h0,        32'h0000_0005, 1'b0, 1'b0, 3'd0, 32'h0000_0005}, // R1
    '{1'b0, 3'd0, 32'h0,        32'h0000_0100, 1'b0, 1'b0, 3'd0, 32'h0000_0105}, // R1
    '{1'b1, 3'd0, 32'h4,        32'h0,         1'b0, 1'b0, 3'd0, 32'h0000_0101}, // R2
    '{1'b1, 3'd1, 32'h101,      32'h0,         1'b0, 1'b0, 3'd2, 32'h0000_0101}, // R4
    '{1'b0, 3'd0, 32'h0,        32'h4000_0000, 1'b0, 1'b0, 3'd2, 32'h0000_0101}, // R4
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b0, 1'b0, 3'd0, 32'h4000_0101}, // R1
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b1, 1'b0, 3'd0, 32'h4002_0101}, // R6
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b0, 1'b1, 3'd0, 32'h400A_0101}, // R6
    '{1'b1, 3'd0, 32'h000A_0000, 32'h300A_0000, 1'b0, 1'b0, 3'd0, 32'h4000_0101}, // R1 R6
    '{1'b1, 3'd0, 32'h1,        32'h0000_0001, 1'b0, 1'b0, 3'd0, 32'h4000_0101}, // R3
    '{1'b1, 3'd3, 32'h0003_0002, 32'h0,        1'b0, 1'b0, 3'd3, 32'h0003_0002}, // R10
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b1, 1'b0, 3'd0, 32'h4000_0101}, // R6
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b1, 1'b0, 3'd0, 32'h4002_0101}, // R6
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b0, 1'b1, 3'd0, 32'h4002_0101}, // R6
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b0, 1'b1, 3'd0, 32'h4002_0101}, // R6
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b0, 1'b1, 3'd0, 32'h400A_0101}, // R6
    '{1'b1, 3'd1, 32'h0,        32'h0,         1'b0, 1'b0, 3'd2, 32'h0000_0000}, // R4
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b0, 1'b0, 3'd0, 32'h400A_0101}, // R4
    '{1'b1, 3'd2, 32'hFFFF_FFFF, 32'h0,        1'b0, 1'b0, 3'd0, 32'h400A_0101}, // R10
    '{1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0,        1'b0, 1'b0, 3'd0, 32'h0000_0000}, // R2
    '{1'b0, 3'd0, 32'h0,        32'h0,         1'b0, 1'b0, 3'd1, 32'h0000_0000}  // R10
  };

  logic        clk, rst_n;
  logic [31:0] evt_i, reg_wdata, reg_rdata;
  logic        rx_done_i, tx_done_i, reg_we, irq_o;
  logic [2:0]  reg_wsel, reg_rsel;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_coal_top u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rx_done_i(rx_done_i), .tx_done_i(tx_done_i),
    .reg_we(reg_we), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata), .reg_rsel(reg_rsel),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    reg_we = 1'b0; evt_i = '0; rx_done_i = 1'b0; tx_done_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    reg_we = 1'b1; reg_wsel = sel; reg_wdata = data;
    step();
    idle();
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] val);
    reg_rsel = sel;
    #1 val = reg_rdata;
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; idle(); reg_wsel = '0; reg_wdata = '0; reg_rsel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset values
    rd(3'd0, v); check("R9 raw", v, 32'h0);
    rd(3'd1, v); check("R9 enable", v, 32'h0);
    rd(3'd2, v); check("R9 status", v, 32'h0);
    rd(3'd3, v); check("R9 thresholds", v, 32'h0001_0001);
    rd(3'd4, v); check("R9 rx timeout", v, 32'h0001_0000);
    rd(3'd5, v); check("R9 tx timeout", v, 32'h0005_0000);
    check("R9 irq", {31'b0, irq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      reg_we = TBL[i].we; reg_wsel = TBL[i].wsel; reg_wdata = TBL[i].wdata;
      evt_i = TBL[i].evt; rx_done_i = TBL[i].rx; tx_done_i = TBL[i].tx;
      reg_rsel = TBL[i].rsel;
      step();
      idle();
      #1 check($sformatf("table row %0d", i), reg_rdata, TBL[i].exp);
    end

    // R5 registered interrupt
    wr(3'd1, 32'h1);
    evt_i = 32'h1;
    step(); idle();
    check("R5 irq one cycle late", {31'b0, irq_o}, 32'h0);
    step();
    check("R5 irq raised", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'h1);
    check("R5 irq held after clear edge", {31'b0, irq_o}, 32'h1);
    step();
    check("R5 irq dropped", {31'b0, irq_o}, 32'h0);

    // R7 timeout timing, R8 pending cleared by timeout
    wr(3'd3, 32'h0004_0004);
    wr(3'd4, 32'd5);
    wr(3'd5, 32'd0);
    wr(3'd0, 32'hFFFF_FFFF);
    rx_done_i = 1'b1; step(); idle();
    repeat (4) step();
    rd(3'd0, v); check("R7 no rx timeout before T", v & 32'h1000_0000, 32'h0);
    step();
    rd(3'd0, v); check("R7 rx timeout at T", v & 32'h1002_0000, 32'h1000_0000);
    rx_done_i = 1'b1; repeat (3) step(); idle();
    rd(3'd0, v); check("R8 count restarted after timeout", v & 32'h0002_0000, 32'h0);

    // R7 zero timeout disables
    tx_done_i = 1'b1; step(); idle();
    repeat (30) step();
    rd(3'd0, v); check("R7 tx timeout disabled", v & 32'h2008_0000, 32'h0);

    // R6 zero threshold acts as one
    wr(3'd3, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    rx_done_i = 1'b1; step(); idle();
    rd(3'd0, v); check("R6 zero threshold", v & 32'h0002_0000, 32'h0002_0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule